// File: doc/BRIEF.md
# Serial DAC Input Interface Controller

This block is the digital front end of a 16-bit serial digital-to-analog converter. A host frames each word with an active-low frame-sync line and a serial clock. Data bits enter an input shift register most significant bit first, one on each falling serial-clock edge. The block copies the captured word into a DAC register in one of two ways: when a load strobe falls, or on its own at the sixteenth bit of a frame while the strobe is held low. It then converts the register into the straight binary code that drives the converter core.

A daisy-chain output repeats the shift register's top bit on rising serial-clock edges, so that a downstream device can sample it on its own falling edges. An asynchronous clear and an asynchronous reset override everything else and force fixed codes. Those codes depend on the format and range inputs.

All serial and strobe pins are sampled by the system clock through a two-stage synchronizer. The serial clock must therefore be much slower than the system clock. The serial interface has no back-pressure. Every falling edge inside a frame is taken, and the core code output is a level that the converter reads at any time, with no valid/ready handshake.

Top module: `sdac_front`

## Requirements
- R1: A falling edge of `sync_n` restarts the bit count. While `sync_n` is low, each falling `sclk` edge shifts `sdin` into the input register, most significant bit first. The register holds the last 16 bits received.
- R2: A falling edge of `ldac_n` copies the input register into the DAC register. Without a load, the DAC register and `core_code` keep their value.
- R3: While `ldac_n` is held low, the DAC register is updated from the input register at the 16th falling `sclk` edge of a frame. A frame that ends before its 16th bit causes no update.
- R4: Bits after the 16th in a frame keep shifting, but they never cause a second automatic update in that frame.
- R5: With `twos_sel` = 0, `core_code` equals the DAC register. With `twos_sel` = 1, `core_code` is the DAC register with bit 15 inverted.
- R6: With `daisy_en` = 1, `sdout` presents bit 15 of the input register and changes only after a rising `sclk` edge. In a long frame, bits 17 to 32 of `sdout` after each rising edge therefore repeat the first word of the frame. With `daisy_en` = 0, `sdout` is 0.
- R7: While `clr_n` is low and `rstin_n` is high, `core_code` is 0x8000 if `bipolar` = 1 and `twos_sel` = 1, and 0x0000 otherwise. Loads are ignored while the clear is active. The clear code remains after `clr_n` rises, until the next load.
- R8: While `rstin_n` is low, and after a system reset (`rst_n` low), `core_code` is 0x8000 if `bipolar` = 1 and 0x0000 if `bipolar` = 0. Loads are ignored while `rstin_n` is low, and the reset code remains until the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sclk | input | 1 | Serial clock, idles high |
| sync_n | input | 1 | Active-low frame sync |
| sdin | input | 1 | Serial data in, MSB first |
| ldac_n | input | 1 | Load strobe; a falling edge loads, held low selects automatic mode |
| clr_n | input | 1 | Asynchronous active-low clear |
| rstin_n | input | 1 | Asynchronous active-low output reset |
| daisy_en | input | 1 | Enables the daisy-chain output |
| twos_sel | input | 1 | 1 = two's complement input format, 0 = straight/offset binary |
| bipolar | input | 1 | 1 = bipolar output range, 0 = unipolar |
| core_code | output | 16 | Straight binary code to the converter core |
| sdout | output | 1 | Daisy-chain serial data out |

## Verification
The first pattern is a full frame with the strobe high, followed by a strobe pulse. It separates strobe loading from automatic loading. The second pattern runs in automatic mode: a 7-bit aborted frame followed by a full frame. This shows both that short frames cause no update and that frame sync restarts the count. A miscounting design would load a mixture of junk bits and new bits. The third pattern is a 32-bit frame with two different words. It shows that the first word is loaded only once, and that the daisy-chain output replays that word bit for bit. Clear and reset are each driven under every combination of range and format that changes their code. Load attempts made during the clear or the reset show that these controls win.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned WORD_W = 16;

  typedef struct packed {
    logic sclk_fall;
    logic sclk_rise;
    logic frame_start;
    logic in_frame;
    logic ldac_fall;
    logic ldac_low;
  } sdac_ev_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= {STAGES{RST_VAL}};
    else        st <= {st[STAGES-2:0], d};
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sdac_edges.sv
module sdac_edges
  import sdac_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sclk,
  input  logic     sync_n,
  input  logic     sdin,
  input  logic     ldac_n,
  output sdac_ev_t ev,
  output logic     sdin_s
);
  logic [3:0] raw, syn;
  logic       sclk_p, sync_p, ldac_p;

  assign raw = {ldac_n, sync_n, sclk, sdin};

  sdac_sync #(.W(4), .STAGES(STAGES), .RST_VAL(4'b1110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= 1'b1;
      sync_p <= 1'b1;
      ldac_p <= 1'b1;
    end else begin
      sclk_p <= syn[1];
      sync_p <= syn[2];
      ldac_p <= syn[3];
    end
  end

  assign sdin_s         = syn[0];
  assign ev.sclk_fall   = sclk_p & ~syn[1];
  assign ev.sclk_rise   = ~sclk_p & syn[1];
  assign ev.frame_start = sync_p & ~syn[2];
  assign ev.in_frame    = ~syn[2];
  assign ev.ldac_fall   = ldac_p & ~syn[3];
  assign ev.ldac_low    = ~syn[3];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
  import sdac_pkg::*;
#(
  parameter int DW = 16,
  localparam int CNT_W = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sdac_ev_t      ev,
  input  logic          sdin_s,
  output logic [DW-1:0] sr,
  output logic          auto_pulse,
  output logic          so_q
);
  logic [CNT_W-1:0] cnt;
  logic             take, last_bit;

  assign take     = ev.sclk_fall & ev.in_frame & ~ev.frame_start;
  assign last_bit = take & (cnt == CNT_W'(DW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr         <= '0;
      cnt        <= '0;
      auto_pulse <= 1'b0;
      so_q       <= 1'b0;
    end else begin
      auto_pulse <= last_bit;
      if (ev.frame_start) begin
        cnt <= '0;
      end else if (take) begin
        sr <= {sr[DW-2:0], sdin_s};
        if (cnt != CNT_W'(DW)) cnt <= cnt + 1'b1;
      end
      if (ev.sclk_rise) so_q <= sr[DW-1];
    end
  end
endmodule

// File: rtl/sdac_dacreg.sv
module sdac_dacreg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  logic          rstin_n,
  input  logic          load_req,
  input  logic [DW-1:0] in_word,
  input  logic          twos_sel,
  input  logic          bipolar,
  output logic [DW-1:0] core_code
);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] dac_q;
  logic          clr_flag, rst_flag, load_ok, rst_arst_n;
  logic [DW-1:0] clr_code, rst_code, data_code;

  assign rst_arst_n = rst_n & rstin_n;
  assign load_ok    = load_req & clr_n & rstin_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dac_q <= '0;
    else if (load_ok) dac_q <= in_word;
  end

  always_ff @(posedge clk or negedge clr_n or negedge rst_n) begin
    if (!clr_n)       clr_flag <= 1'b1;
    else if (!rst_n)  clr_flag <= 1'b0;
    else if (load_ok) clr_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_arst_n) begin
    if (!rst_arst_n)  rst_flag <= 1'b1;
    else if (load_ok) rst_flag <= 1'b0;
  end

  assign clr_code  = (bipolar & twos_sel) ? MID : '0;
  assign rst_code  = bipolar ? MID : '0;
  assign data_code = twos_sel ? {~dac_q[DW-1], dac_q[DW-2:0]} : dac_q;

  always_comb begin
    if (!rstin_n)      core_code = rst_code;
    else if (clr_flag) core_code = clr_code;
    else if (rst_flag) core_code = rst_code;
    else               core_code = data_code;
  end
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          sync_n,
  input  logic          sdin,
  input  logic          ldac_n,
  input  logic          clr_n,
  input  logic          rstin_n,
  input  logic          daisy_en,
  input  logic          twos_sel,
  input  logic          bipolar,
  output logic [DW-1:0] core_code,
  output logic          sdout
);
  sdac_ev_t      ev;
  logic          sdin_s, auto_pulse, so_q, load_req;
  logic [DW-1:0] sr;

  sdac_edges #(.STAGES(SYNC_STAGES)) u_edges (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n),
    .sdin(sdin), .ldac_n(ldac_n), .ev(ev), .sdin_s(sdin_s)
  );

  sdac_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .ev(ev), .sdin_s(sdin_s),
    .sr(sr), .auto_pulse(auto_pulse), .so_q(so_q)
  );

  assign load_req = ev.ldac_fall | (auto_pulse & ev.ldac_low);

  sdac_dacreg #(.DW(DW)) u_dac (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .rstin_n(rstin_n),
    .load_req(load_req), .in_word(sr), .twos_sel(twos_sel),
    .bipolar(bipolar), .core_code(core_code)
  );

  assign sdout = daisy_en & so_q;
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_n,
  input logic          rstin_n,
  input logic          twos_sel,
  input logic          bipolar,
  input logic          daisy_en,
  input logic [DW-1:0] core_code,
  input logic          sdout,
  input logic          load_req,
  input logic          sclk_rise,
  input logic          auto_pulse,
  input logic          frame_start
);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  logic [1:0] autos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            autos_q <= '0;
    else if (frame_start)                  autos_q <= '0;
    else if (auto_pulse && autos_q != 2'd3) autos_q <= autos_q + 1'b1;
  end

  assert_clear_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && rstin_n) |-> core_code == ((bipolar && twos_sel) ? MID : '0));

  assert_reset_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rstin_n |-> core_code == (bipolar ? MID : '0));

  assert_hold_without_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && rstin_n && $past(clr_n) && $past(rstin_n) && $stable(twos_sel)
     && $stable(bipolar) && core_code != $past(core_code)) |-> $past(load_req));

  assert_sdout_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (daisy_en && $past(daisy_en) && sdout != $past(sdout)) |-> $past(sclk_rise));

  assert_one_auto_R4: assert property (@(posedge clk) disable iff (!rst_n)
    autos_q < 2'd2);
endmodule

bind sdac_front sdac_front_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .rstin_n(rstin_n),
  .twos_sel(twos_sel), .bipolar(bipolar), .daisy_en(daisy_en),
  .core_code(core_code), .sdout(sdout), .load_req(load_req),
  .sclk_rise(ev.sclk_rise), .auto_pulse(auto_pulse),
  .frame_start(ev.frame_start)
);

// File: tb/sim_sdac_front.sv
`timescale 1ns/1ps
module sim_sdac_front;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sync_n = 1'b1, sdin = 1'b0, ldac_n = 1'b1;
  logic clr_n = 1'b1, rstin_n = 1'b1, daisy_en = 1'b0;
  logic twos_sel = 1'b0, bipolar = 1'b0;
  logic [15:0] core_code;
  logic sdout;
  logic [63:0] cap;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdac_front u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
    .ldac_n(ldac_n), .clr_n(clr_n), .rstin_n(rstin_n), .daisy_en(daisy_en),
    .twos_sel(twos_sel), .bipolar(bipolar), .core_code(core_code), .sdout(sdout)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [63:0] b, input int n);
    cap = '0;
    sync_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      sdin = b[n-1-i];
      tick(H);
      sclk = 1'b0;
      tick(H);
      sclk = 1'b1;
      tick(6);
      cap[i] = sdout;
    end
    tick(H);
    sync_n = 1'b1;
    tick(10);
  endtask

  task automatic pulse_ldac();
    ldac_n = 1'b0;
    tick(10);
    ldac_n = 1'b1;
    tick(10);
  endtask

  task automatic t_reset();
    check("R8 reset code unipolar", core_code, 16'h0000);
    check("R6 sdout low after reset", {15'd0, sdout}, 16'h0000);
  endtask

  task automatic t_manual_load();
    send_bits(64'h1234, 16);
    check("R2 no load without strobe", core_code, 16'h0000);
    pulse_ldac();
    check("R2 strobe loads word", core_code, 16'h1234);
  endtask

  task automatic t_auto();
    ldac_n = 1'b0;
    tick(10);
    send_bits(64'h55, 7);
    check("R3 short frame no update", core_code, 16'h1234);
    send_bits(64'hA5C3, 16);
    check("R1 R3 auto load after resync", core_code, 16'hA5C3);
  endtask

  task automatic t_chain();
    logic [15:0] got;
    daisy_en = 1'b1;
    send_bits({32'd0, 16'h3C96, 16'hF00D}, 32);
    check("R4 single auto load in long frame", core_code, 16'h3C96);
    got = '0;
    for (int k = 16; k <= 31; k++) got[31-k] = cap[k-1];
    check("R6 daisy output replays first word", got, 16'h3C96);
  endtask

  task automatic t_daisy_off();
    daisy_en = 1'b0;
    send_bits(64'hFFFF, 16);
    check("R6 sdout held low when disabled", cap[15:0], 16'h0000);
    check("R3 auto load all ones", core_code, 16'hFFFF);
  endtask

  task automatic t_format();
    bipolar = 1'b1;
    twos_sel = 1'b1;
    tick(2);
    check("R5 twos msb inverted ffff", core_code, 16'h7FFF);
    send_bits(64'h0001, 16);
    check("R5 twos msb inverted 0001", core_code, 16'h8001);
    twos_sel = 1'b0;
    tick(2);
    check("R5 binary passthrough", core_code, 16'h0001);
  endtask

  task automatic t_clear();
    twos_sel = 1'b1;
    clr_n = 1'b0;
    tick(3);
    check("R7 clear bipolar twos", core_code, 16'h8000);
    twos_sel = 1'b0;
    tick(2);
    check("R7 clear bipolar offset", core_code, 16'h0000);
    bipolar = 1'b0;
    twos_sel = 1'b1;
    tick(2);
    check("R7 clear unipolar", core_code, 16'h0000);
    twos_sel = 1'b0;
    ldac_n = 1'b1;
    tick(10);
    send_bits(64'h4242, 16);
    pulse_ldac();
    check("R7 load ignored during clear", core_code, 16'h0000);
    clr_n = 1'b1;
    tick(10);
    check("R7 clear code held after release", core_code, 16'h0000);
    pulse_ldac();
    check("R7 load after clear", core_code, 16'h4242);
  endtask

  task automatic t_outreset();
    bipolar = 1'b1;
    rstin_n = 1'b0;
    tick(3);
    check("R8 reset bipolar", core_code, 16'h8000);
    pulse_ldac();
    check("R8 load ignored during reset", core_code, 16'h8000);
    bipolar = 1'b0;
    tick(2);
    check("R8 reset unipolar", core_code, 16'h0000);
    rstin_n = 1'b1;
    tick(10);
    check("R8 reset code held after release", core_code, 16'h0000);
    bipolar = 1'b1;
    tick(2);
    check("R8 held reset code follows range", core_code, 16'h8000);
    pulse_ldac();
    check("R8 load after reset", core_code, 16'h4242);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_manual_load();
    t_auto();
    t_chain();
    t_daisy_off();
    t_format();
    t_clear();
    t_outreset();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule